// File: doc/BRIEF.md
# VMEbus Short I/O Slave Cycle Qualifier

This block sits between the VMEbus data-transfer lines and the transfer sequencer of a byte-wide peripheral bridge. It watches the A16 address lines A15–A01, the address modifier code, the address and data strobes and the direction line. It decides whether the current bus cycle belongs to this slave and is one it serves. A static base setting picks which 1 KB window of short I/O space the bridge occupies. A static supervisory-only setting picks which access privileges are honoured.

The bridge carries data only on the odd (low) byte lane. Inside the window, each of the 64 peripheral banks sits at an odd offset. Two further odd offsets form a write-only register that raises and drops a peripheral reset level. The block reports a registered select strobe, the direction, the local byte offset, the decoded bank number and a reset-register hit. It also holds the peripheral reset level itself. Every other offset in the window is left unselected. The block never acknowledges such a cycle, so the bus times it out.

All bus inputs and the two settings pass through one capture register, and the decode result is registered again. Each output therefore reflects the bus as it stood two clock edges earlier.

Top module: `vme_sio_decoder`

## Requirements
- R1: A cycle is selected only when address bits A15–A10 equal the 6-bit `cfg_base` setting, so any of the 64 1 KB boundaries can be chosen.
- R2: With `cfg_sup_only` = 1, only modifier code 2DH is accepted. With `cfg_sup_only` = 0, both 2DH and 29H are accepted. Every other code is never selected.
- R3: Selection needs the address strobe low and DS0* low. A cycle with only DS1* low is ignored. A cycle with both data strobes low is served on the low lane.
- R4: Byte offsets 01H to 7FH (A9–A7 zero, A0 implied 1) are bank accesses, read or write. `bank_hit_o` = 1, `bank_o` = (offset − 1)/2 (equal to A6–A1), and `offs_o` carries the 10-bit byte offset with bit 0 set.
- R5: A write to offset 81H raises `rst_hit_o` and sets the peripheral reset level. A write to offset C1H raises `rst_hit_o` and clears it. A read of either offset is not selected.
- R6: An offset in the window that is neither a bank nor a write to a reset offset (for example 83H, 101H, 3FFH) gives `sel_o` = 0, `bank_hit_o` = 0 and `rst_hit_o` = 0.
- R7: After the synchronous reset `rst`, `periph_rst_o` = 1 and `sel_o` = 0. `periph_rst_o` changes only in the cycle where `rst_hit_o` is 1.
- R8: `wr_o` is 1 for a selected cycle with WRITE* low and 0 when WRITE* is high.
- R9: Outputs show the bus two rising clock edges after it is applied. `sel_o` falls two edges after DS0* rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| vme_addr | input | 15 | Address lines A15–A01 |
| vme_am | input | 6 | Address modifier code |
| vme_as_n | input | 1 | Address strobe, active low |
| vme_ds0_n | input | 1 | Low-lane data strobe, active low |
| vme_ds1_n | input | 1 | High-lane data strobe, active low (not used for selection) |
| vme_write_n | input | 1 | Direction, low means write |
| cfg_base | input | 6 | Window base, compared with A15–A10 |
| cfg_sup_only | input | 1 | 1 restricts access to supervisory code 2DH |
| sel_o | output | 1 | Registered cycle select for the sequencer |
| wr_o | output | 1 | Direction of the selected cycle, 1 = write |
| offs_o | output | 10 | Local byte offset in the window |
| bank_hit_o | output | 1 | Selected cycle targets a peripheral bank |
| bank_o | output | 6 | Peripheral bank number |
| rst_hit_o | output | 1 | Selected cycle writes the reset register |
| periph_rst_o | output | 1 | Peripheral reset level, 1 = asserted |

## Verification
Bank 12 at offset 19H is driven under every one of the 64 base settings, once with each modifier code and in both privilege modes. This separates a wrong bit in the window compare from a wrong modifier filter. Directed lane cases set DS1* alone, both strobes and a missing address strobe, and so separate the low-lane rule from a generic any-strobe select. Reads and writes of the two reset offsets, bank 0, bank 63 and offsets just outside the bank range show whether the offset split is exact. Random cycles with biased address, modifier and strobe choices then mix all of these against a bench-side model that also tracks the reset level.

// File: rtl/vsd_pkg.sv
package vsd_pkg;
  localparam int ADDR_W = 16;                // A16 short I/O space
  localparam int WIN_W  = 10;                // 1 KB window
  localparam int BASE_W = ADDR_W - WIN_W;    // compared upper bits
  localparam int AM_W   = 6;
  localparam int BANK_W = 6;                 // 64 banks

  typedef struct packed {
    logic [ADDR_W-1:1] addr;
    logic [AM_W-1:0]   am;
    logic              as_n;
    logic              ds0_n;
    logic              write_n;
  } vsd_bus_t;

  localparam vsd_bus_t VSD_IDLE = '{addr: '0, am: '0, as_n: 1'b1,
                                    ds0_n: 1'b1, write_n: 1'b1};

  typedef struct packed {
    logic              sel;
    logic              wr;
    logic              bank_hit;
    logic              rst_hit;
    logic              rst_on;
    logic [BANK_W-1:0] bank;
    logic [WIN_W-1:0]  offs;
  } vsd_dec_t;
endpackage

// File: rtl/vsd_capture.sv
module vsd_capture
  import vsd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  vsd_bus_t          bus_i,
  input  logic [BASE_W-1:0] base_i,
  input  logic              sup_i,
  output vsd_bus_t          bus_q,
  output logic [BASE_W-1:0] base_q,
  output logic              sup_q
);
  // one register on every bus and setting input: the decode sees a
  // coherent snapshot taken at a single edge
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_q  <= VSD_IDLE;
      base_q <= '0;
      sup_q  <= 1'b1;
    end else begin
      bus_q  <= bus_i;
      base_q <= base_i;
      sup_q  <= sup_i;
    end
  end
endmodule

// File: rtl/vsd_qualify.sv
module vsd_qualify
  import vsd_pkg::*;
#(
  parameter logic [AM_W-1:0] AM_SUP  = 6'h2D,
  parameter logic [AM_W-1:0] AM_USER = 6'h29
) (
  input  vsd_bus_t          bus,
  input  logic [BASE_W-1:0] base,
  input  logic              sup_only,
  output logic              cyc_ok
);
  logic am_ok;
  logic base_ok;
  logic strobe_ok;

  always_comb begin
    am_ok     = (bus.am == AM_SUP) || (!sup_only && (bus.am == AM_USER));
    base_ok   = (bus.addr[ADDR_W-1:WIN_W] == base);
    // only the low lane carries data; the high-lane strobe plays no part
    strobe_ok = !bus.as_n && !bus.ds0_n;
    cyc_ok    = am_ok && base_ok && strobe_ok;
  end
endmodule

// File: rtl/vsd_split.sv
module vsd_split
  import vsd_pkg::*;
#(
  parameter logic [WIN_W-1:0] RST_ON_OFS  = 10'h081,
  parameter logic [WIN_W-1:0] RST_OFF_OFS = 10'h0C1
) (
  input  logic [WIN_W-1:1]  offs_hi,
  input  logic              is_write,
  output logic              bank_hit,
  output logic              rst_hit,
  output logic              rst_on,
  output logic [BANK_W-1:0] bank
);
  localparam int REGION_LO = BANK_W + 1;

  logic on_match;
  logic off_match;

  always_comb begin
    bank_hit  = (offs_hi[WIN_W-1:REGION_LO] == '0);
    bank      = offs_hi[BANK_W:1];
    on_match  = (offs_hi == RST_ON_OFS[WIN_W-1:1]);
    off_match = (offs_hi == RST_OFF_OFS[WIN_W-1:1]);
    rst_hit   = is_write && (on_match || off_match);
    rst_on    = on_match;
  end
endmodule

// File: rtl/vme_sio_decoder.sv
module vme_sio_decoder
  import vsd_pkg::*;
#(
  parameter logic [AM_W-1:0]  AM_SUP      = 6'h2D,
  parameter logic [AM_W-1:0]  AM_USER     = 6'h29,
  parameter logic [WIN_W-1:0] RST_ON_OFS  = 10'h081,
  parameter logic [WIN_W-1:0] RST_OFF_OFS = 10'h0C1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:1] vme_addr,
  input  logic [AM_W-1:0]   vme_am,
  input  logic              vme_as_n,
  input  logic              vme_ds0_n,
  input  logic              vme_ds1_n,
  input  logic              vme_write_n,
  input  logic [BASE_W-1:0] cfg_base,
  input  logic              cfg_sup_only,
  output logic              sel_o,
  output logic              wr_o,
  output logic [WIN_W-1:0]  offs_o,
  output logic              bank_hit_o,
  output logic [BANK_W-1:0] bank_o,
  output logic              rst_hit_o,
  output logic              periph_rst_o
);
  vsd_bus_t          bus_in;
  vsd_bus_t          bus_q;
  logic [BASE_W-1:0] base_q;
  logic              sup_q;
  logic              cyc_ok;
  logic              bank_hit;
  logic              rst_hit;
  logic              rst_on;
  logic [BANK_W-1:0] bank;
  vsd_dec_t          dec;
  vsd_dec_t          dec_q;
  logic              prst_q;
  logic              unused_ds1;

  assign unused_ds1 = vme_ds1_n;

  always_comb begin
    bus_in         = VSD_IDLE;
    bus_in.addr    = vme_addr;
    bus_in.am      = vme_am;
    bus_in.as_n    = vme_as_n;
    bus_in.ds0_n   = vme_ds0_n;
    bus_in.write_n = vme_write_n;
  end

  vsd_capture u_cap (
    .clk   (clk),
    .rst   (rst),
    .bus_i (bus_in),
    .base_i(cfg_base),
    .sup_i (cfg_sup_only),
    .bus_q (bus_q),
    .base_q(base_q),
    .sup_q (sup_q)
  );

  vsd_qualify #(.AM_SUP(AM_SUP), .AM_USER(AM_USER)) u_qual (
    .bus     (bus_q),
    .base    (base_q),
    .sup_only(sup_q),
    .cyc_ok  (cyc_ok)
  );

  vsd_split #(.RST_ON_OFS(RST_ON_OFS), .RST_OFF_OFS(RST_OFF_OFS)) u_split (
    .offs_hi (bus_q.addr[WIN_W-1:1]),
    .is_write(!bus_q.write_n),
    .bank_hit(bank_hit),
    .rst_hit (rst_hit),
    .rst_on  (rst_on),
    .bank    (bank)
  );

  always_comb begin
    dec.bank_hit = cyc_ok && bank_hit;
    dec.rst_hit  = cyc_ok && rst_hit;
    dec.sel      = dec.bank_hit || dec.rst_hit;
    dec.wr       = !bus_q.write_n;
    dec.rst_on   = rst_on;
    dec.bank     = bank;
    dec.offs     = {bus_q.addr[WIN_W-1:1], 1'b1};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_q  <= '0;
      prst_q <= 1'b1;
    end else begin
      dec_q <= dec;
      if (dec.rst_hit) prst_q <= dec.rst_on;
    end
  end

  assign sel_o        = dec_q.sel;
  assign wr_o         = dec_q.wr;
  assign offs_o       = dec_q.offs;
  assign bank_hit_o   = dec_q.bank_hit;
  assign bank_o       = dec_q.bank;
  assign rst_hit_o    = dec_q.rst_hit;
  assign periph_rst_o = prst_q;
endmodule

// File: rtl/vsd_checker.sv
module vsd_checker
  import vsd_pkg::*;
#(
  parameter logic [AM_W-1:0] AM_SUP  = 6'h2D,
  parameter logic [AM_W-1:0] AM_USER = 6'h29
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:1] vme_addr,
  input logic [AM_W-1:0]   vme_am,
  input logic              vme_as_n,
  input logic              vme_ds0_n,
  input logic              vme_write_n,
  input logic [BASE_W-1:0] cfg_base,
  input logic              cfg_sup_only,
  input logic              sel_o,
  input logic              wr_o,
  input logic              bank_hit_o,
  input logic [BANK_W-1:0] bank_o,
  input logic              rst_hit_o,
  input logic              periph_rst_o
);
  p_base_match_r1: assert property (@(posedge clk) disable iff (rst)
    sel_o |-> ($past(vme_addr[ADDR_W-1:WIN_W], 2) == $past(cfg_base, 2)));

  p_am_filter_r2: assert property (@(posedge clk) disable iff (rst)
    sel_o |-> (($past(vme_am, 2) == AM_SUP) ||
               (!$past(cfg_sup_only, 2) && ($past(vme_am, 2) == AM_USER))));

  p_low_lane_r3: assert property (@(posedge clk) disable iff (rst)
    sel_o |-> (!$past(vme_ds0_n, 2) && !$past(vme_as_n, 2)));

  p_bank_num_r4: assert property (@(posedge clk) disable iff (rst)
    bank_hit_o |-> (sel_o && (bank_o == $past(vme_addr[BANK_W:1], 2))));

  p_rst_write_r5: assert property (@(posedge clk) disable iff (rst)
    rst_hit_o |-> (sel_o && wr_o && !bank_hit_o));

  p_known_only_r6: assert property (@(posedge clk) disable iff (rst)
    sel_o |-> (bank_hit_o || rst_hit_o));

  p_prst_change_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(periph_rst_o) |-> rst_hit_o);

  p_reset_state_r7: assert property (@(posedge clk)
    rst |=> (periph_rst_o && !sel_o));

  p_direction_r8: assert property (@(posedge clk) disable iff (rst)
    sel_o |-> (wr_o == !$past(vme_write_n, 2)));
endmodule

bind vme_sio_decoder vsd_checker #(.AM_SUP(AM_SUP), .AM_USER(AM_USER)) u_vsd_chk (
  .clk         (clk),
  .rst         (rst),
  .vme_addr    (vme_addr),
  .vme_am      (vme_am),
  .vme_as_n    (vme_as_n),
  .vme_ds0_n   (vme_ds0_n),
  .vme_write_n (vme_write_n),
  .cfg_base    (cfg_base),
  .cfg_sup_only(cfg_sup_only),
  .sel_o       (sel_o),
  .wr_o        (wr_o),
  .bank_hit_o  (bank_hit_o),
  .bank_o      (bank_o),
  .rst_hit_o   (rst_hit_o),
  .periph_rst_o(periph_rst_o)
);

// File: tb/vme_sio_decoder_test.sv
`timescale 1ns/1ps
module vme_sio_decoder_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:1] vme_addr = '0;
  logic [5:0]  vme_am = '0;
  logic        vme_as_n = 1'b1;
  logic        vme_ds0_n = 1'b1;
  logic        vme_ds1_n = 1'b1;
  logic        vme_write_n = 1'b1;
  logic [5:0]  cfg_base = '0;
  logic        cfg_sup_only = 1'b0;
  logic        sel_o, wr_o, bank_hit_o, rst_hit_o, periph_rst_o;
  logic [9:0]  offs_o;
  logic [5:0]  bank_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  bit m_prst = 1'b1;   // bench model of the peripheral reset level

  always #2 clk = ~clk;   // 250 MHz

  vme_sio_decoder uut (
    .clk(clk), .rst(rst), .vme_addr(vme_addr), .vme_am(vme_am),
    .vme_as_n(vme_as_n), .vme_ds0_n(vme_ds0_n), .vme_ds1_n(vme_ds1_n),
    .vme_write_n(vme_write_n), .cfg_base(cfg_base), .cfg_sup_only(cfg_sup_only),
    .sel_o(sel_o), .wr_o(wr_o), .offs_o(offs_o), .bank_hit_o(bank_hit_o),
    .bank_o(bank_o), .rst_hit_o(rst_hit_o), .periph_rst_o(periph_rst_o)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // expected {sel, bank_hit, rst_hit, rst_on} from the requirements
  function automatic logic [3:0] model(logic [15:0] ba, logic [5:0] am, logic as_n,
                                       logic ds0_n, logic wr_n, logic [5:0] base, logic sup);
    logic [9:0] off;
    logic am_ok, cyc, bk, rh, on;
    off   = {ba[9:1], 1'b1};
    am_ok = (am == 6'h2D) || (!sup && am == 6'h29);
    cyc   = !as_n && !ds0_n && am_ok && (ba[15:10] == base);
    bk    = cyc && (off <= 10'h07F);
    on    = (off == 10'h081);
    rh    = cyc && !wr_n && (on || off == 10'h0C1);
    return {bk || rh, bk, rh, on};
  endfunction

  task automatic apply(string req, logic [15:0] ba, logic [5:0] am, logic as_n,
                       logic ds0_n, logic ds1_n, logic wr_n);
    logic [3:0] e;
    logic [9:0] eoff;
    vme_addr = ba[15:1]; vme_am = am; vme_as_n = as_n;
    vme_ds0_n = ds0_n; vme_ds1_n = ds1_n; vme_write_n = wr_n;
    e    = model(ba, am, as_n, ds0_n, wr_n, cfg_base, cfg_sup_only);
    eoff = {ba[9:1], 1'b1};
    @(posedge clk); @(posedge clk); @(negedge clk);
    if (e[1]) m_prst = e[0];
    check(req, "sel", sel_o, e[3]);
    check("R4", "bank_hit", bank_hit_o, e[2]);
    check("R5", "rst_hit", rst_hit_o, e[1]);
    check("R7", "periph_rst", periph_rst_o, m_prst);
    if (e[3]) begin
      check("R8", "wr", wr_o, !wr_n);
      check("R4", "offs", offs_o, eoff);
    end
    if (e[2]) check("R4", "bank", bank_o, (eoff - 10'd1) >> 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL R9 watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd1729);
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R7 reset state
    check("R7", "reset sel", sel_o, 0);
    check("R7", "reset periph_rst", periph_rst_o, 1);
    rst = 1'b0;

    // R1 R2: bank 12 at 19H across all bases, both codes, both modes
    for (int b = 0; b < 64; b++) begin
      cfg_base = b[5:0];
      cfg_sup_only = b[0];
      apply("R1", {b[5:0], 10'h019}, 6'h2D, 0, 0, 1, 1);
      apply("R2", {b[5:0], 10'h019}, 6'h29, 0, 0, 1, 0);
      apply("R1", {b[5:0] ^ 6'h20, 10'h019}, 6'h2D, 0, 0, 1, 1);
    end
    cfg_base = 6'h04; cfg_sup_only = 1'b0;
    apply("R2", 16'h1019, 6'h39, 0, 0, 1, 1);        // foreign code
    // R3 byte lanes and address strobe
    apply("R3", 16'h1019, 6'h2D, 0, 1, 0, 1);        // DS1* alone
    apply("R3", 16'h1019, 6'h2D, 0, 0, 0, 1);        // word
    apply("R3", 16'h1019, 6'h2D, 1, 0, 1, 1);        // no AS*
    // R4 bank edges
    apply("R4", 16'h1001, 6'h2D, 0, 0, 1, 0);
    apply("R4", 16'h107F, 6'h29, 0, 0, 1, 1);
    // R5 reset register
    apply("R5", 16'h10C1, 6'h2D, 0, 0, 1, 0);        // release
    apply("R5", 16'h1081, 6'h2D, 0, 0, 1, 1);        // read: ignored
    apply("R5", 16'h1081, 6'h2D, 0, 0, 1, 0);        // assert
    apply("R5", 16'h10C1, 6'h2D, 0, 0, 1, 1);        // read: ignored
    apply("R5", 16'h10C1, 6'h2D, 0, 0, 1, 0);        // release
    // R6 unused offsets
    apply("R6", 16'h1083, 6'h2D, 0, 0, 1, 0);
    apply("R6", 16'h1101, 6'h2D, 0, 0, 1, 1);
    apply("R6", 16'h13FF, 6'h2D, 0, 0, 1, 0);

    // R9 latency and drop
    vme_as_n = 1; vme_ds0_n = 1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    vme_addr = 15'h1019 >> 1; vme_addr = 16'h1019 >> 1; vme_am = 6'h2D;
    vme_as_n = 0; vme_ds0_n = 0; vme_write_n = 1;
    @(posedge clk); @(negedge clk);
    check("R9", "sel after one edge", sel_o, 0);
    @(posedge clk); @(negedge clk);
    check("R9", "sel after two edges", sel_o, 1);
    vme_ds0_n = 1;
    @(posedge clk); @(negedge clk);
    check("R9", "sel one edge after DS0 rise", sel_o, 1);
    @(posedge clk); @(negedge clk);
    check("R9", "sel two edges after DS0 rise", sel_o, 0);

    // random mix
    for (int i = 0; i < 800; i++) begin
      logic [15:0] ba;
      logic [5:0]  am;
      int r;
      if ((i % 50) == 0) begin
        cfg_base = 6'($urandom);
        cfg_sup_only = 1'($urandom);
      end
      r = $urandom % 4;
      case (r)
        0, 1: ba[9:0] = {3'b000, 6'($urandom), 1'b1};
        2:    ba[9:0] = ($urandom % 2) ? 10'h081 : 10'h0C1;
        default: ba[9:0] = 10'($urandom);
      endcase
      ba[15:10] = (($urandom % 10) < 7) ? cfg_base : 6'($urandom);
      r = $urandom % 3;
      am = (r == 0) ? 6'h2D : (r == 1) ? 6'h29 : 6'($urandom);
      apply("R2", ba, am, (($urandom % 8) == 0), (($urandom % 6) == 0),
            1'($urandom), 1'($urandom));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule